// File: doc/BRIEF.md
# Dual-Channel Transmit Request Status Controller

This block tells a host processor when encoded transmit data for either of two channels is waiting in its buffer. Each channel raises a one-cycle "buffer full" pulse. The block turns that pulse into a request flag and drives an active-low request line. It then counts a programmable read window while the host reads the buffer. If the host's read-complete pulse arrives inside the window, the request ends cleanly. If the window runs out first, the request is withdrawn and a per-channel late-read error is latched.

Only one request is active at any time, and channel 0 wins over channel 1. Between two requests the request line goes high for at least one cycle, so every request gives the host its own falling edge. In two-channel mode each frame carries a channel 0 request followed by a channel 1 request. A frame-start flag marks which of the two is in progress. In single-channel mode, buffer-full pulses from channel 1 are dropped.

An 8-bit read-only status word reports the following: the codec type, the buffering period, the two-channel mode, the frame-start flag, both error flags and both request flags.

Top module: `txreq_status_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `status` reads 0x00 and `req_n` is high until the first request.
- R2: Status bit 7 shows `codec_pcm` one clock late: 1 means the companded pulse-code codec mode, 0 means any other codec mode.
- R3: Status bit 6 shows `buf_20ms` one clock late: 0 means 10 ms of data is buffered per request, 1 means 20 ms.
- R4: Status bit 5 shows `dual_mode` one clock late: 1 means two-channel mode is active.
- R5: A `full_pulse[c]` marks channel c as pending. A pending channel is granted when no request is active, with channel 0 before channel 1. A grant sets status bit c (bit 0 for channel 0, bit 1 for channel 1) at the next edge. A pulse on an idle block therefore shows at the second clock edge after it is sampled. At most one request flag is ever set.
- R6: A `done_pulse[c]` seen while channel c's request is active clears that request flag and that channel's error flag (bit 2 for channel 0, bit 3 for channel 1) at the next edge.
- R7: A request with no read-complete pulse stays active for exactly `rd_window` clocks, where a value of 0 counts as 1. At expiry the request flag clears and the channel's error flag sets at the same edge. An error flag keeps its value until that channel's next request ends.
- R8: `req_n` is low exactly while a request flag is set. Between two consecutive requests it is high for at least one clock.
- R9: In two-channel mode, status bit 4 sets at the edge where a channel 0 request is granted and clears at the edge where a channel 1 request is granted. In single-channel mode it reads 0.
- R10: While `dual_mode` is 0, `full_pulse[1]` has no effect, and any pending channel 1 request is dropped.
- R11: A `done_pulse[c]` that arrives while channel c has no active request has no effect on any status bit or on `req_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_pulse | input | 2 | One-cycle buffer-full pulse per channel |
| done_pulse | input | 2 | One-cycle read-complete pulse per channel |
| dual_mode | input | 1 | Two-channel operation enable |
| codec_pcm | input | 1 | Codec is in companded pulse-code mode |
| buf_20ms | input | 1 | Buffering period select: 0 = 10 ms, 1 = 20 ms |
| rd_window | input | WIN_W | Valid read window length in clocks |
| req_n | output | 1 | Active-low transmit request line |
| status | output | 8 | Read-only status word |

## Verification
The bench aims both channels' buffer-full pulses at the same cycle. A design that ignored priority or allowed overlap would show both request flags at once, or would skip the high gap on `req_n`. It checks windows of 0, 1 and several clocks, and a read-complete pulse on the last window cycle. An off-by-one counter would either drop the request a cycle early or miss the error, and a wrong priority between completion and expiry would latch a spurious error. It also sends channel 1 pulses in single-channel mode and stray read-complete pulses on idle channels. A design that leaked either would raise a request or clear an error that should stay.

// File: rtl/txreq_pkg.sv
package txreq_pkg;
  localparam int NUM_CH     = 2;
  localparam int STAT_W     = 8;
  localparam int BIT_CODEC  = 7;
  localparam int BIT_PERIOD = 6;
  localparam int BIT_DUAL   = 5;
  localparam int BIT_FIRST  = 4;
  localparam int BIT_ERR0   = 2;
  localparam int BIT_REQ0   = 0;

  // Window load value: a zero length still gives one cycle.
  function automatic logic [15:0] win_load(input logic [15:0] len);
    return (len == 16'd0) ? 16'd1 : len;
  endfunction
endpackage

// File: rtl/txreq_window.sv
module txreq_window #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  input  logic             done,
  input  logic [WIN_W-1:0] rd_window,
  output logic             active,
  output logic             expire,
  output logic             complete,
  output logic             err
);
  import txreq_pkg::*;

  logic [WIN_W-1:0] remain;
  logic [15:0]      load_wide;

  assign load_wide = win_load(16'(rd_window));
  assign complete  = active & done;
  assign expire    = active & ~done & (remain == WIN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      remain <= '0;
      err    <= 1'b0;
    end else begin
      if (grant) begin
        active <= 1'b1;
        remain <= load_wide[WIN_W-1:0];
      end else if (complete) begin
        active <= 1'b0;
        err    <= 1'b0;
      end else if (expire) begin
        active <= 1'b0;
        err    <= 1'b1;
      end else if (active) begin
        remain <= remain - WIN_W'(1);
      end
    end
  end
endmodule

// File: rtl/txreq_arbiter.sv
module txreq_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] full_pulse,
  input  logic       dual_mode,
  input  logic       any_active,
  output logic [1:0] grant
);
  logic [1:0] pend;
  logic [1:0] accept;

  assign accept[0] = full_pulse[0];
  assign accept[1] = full_pulse[1] & dual_mode;
  assign grant[0]  = pend[0] & ~any_active;
  assign grant[1]  = pend[1] & ~pend[0] & ~any_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else begin
      pend[0] <= accept[0] | (pend[0] & ~grant[0]);
      pend[1] <= dual_mode & (accept[1] | (pend[1] & ~grant[1]));
    end
  end
endmodule

// File: rtl/txreq_status_reg.sv
module txreq_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       codec_pcm,
  input  logic       buf_20ms,
  input  logic       dual_mode,
  input  logic [1:0] grant,
  input  logic [1:0] err,
  input  logic [1:0] active,
  output logic [7:0] status
);
  import txreq_pkg::*;

  logic codec_q, period_q, dual_q, first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codec_q  <= 1'b0;
      period_q <= 1'b0;
      dual_q   <= 1'b0;
      first_q  <= 1'b0;
    end else begin
      codec_q  <= codec_pcm;
      period_q <= buf_20ms;
      dual_q   <= dual_mode;
      if (!dual_mode)    first_q <= 1'b0;
      else if (grant[0]) first_q <= 1'b1;
      else if (grant[1]) first_q <= 1'b0;
    end
  end

  always_comb begin
    status             = '0;
    status[BIT_CODEC]  = codec_q;
    status[BIT_PERIOD] = period_q;
    status[BIT_DUAL]   = dual_q;
    status[BIT_FIRST]  = first_q;
    status[BIT_ERR0+1:BIT_ERR0] = err;
    status[BIT_REQ0+1:BIT_REQ0] = active;
  end
endmodule

// File: rtl/txreq_status_ctrl.sv
module txreq_status_ctrl #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       full_pulse,
  input  logic [1:0]       done_pulse,
  input  logic             dual_mode,
  input  logic             codec_pcm,
  input  logic             buf_20ms,
  input  logic [WIN_W-1:0] rd_window,
  output logic             req_n,
  output logic [7:0]       status
);
  import txreq_pkg::*;

  logic [NUM_CH-1:0] grant;
  logic [NUM_CH-1:0] active;
  logic [NUM_CH-1:0] expire;
  logic [NUM_CH-1:0] complete;
  logic [NUM_CH-1:0] err;
  logic              any_active;

  assign any_active = |active;
  assign req_n      = ~any_active;

  txreq_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .full_pulse(full_pulse),
    .dual_mode(dual_mode), .any_active(any_active), .grant(grant)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    txreq_window #(.WIN_W(WIN_W)) u_win (
      .clk(clk), .rst_n(rst_n), .grant(grant[c]), .done(done_pulse[c]),
      .rd_window(rd_window), .active(active[c]), .expire(expire[c]),
      .complete(complete[c]), .err(err[c])
    );
  end

  txreq_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .codec_pcm(codec_pcm), .buf_20ms(buf_20ms),
    .dual_mode(dual_mode), .grant(grant), .err(err), .active(active),
    .status(status)
  );
endmodule

// File: rtl/txreq_checker.sv
module txreq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_n,
  input logic [7:0] status,
  input logic       dual_mode,
  input logic [1:0] grant,
  input logic [1:0] expire,
  input logic [1:0] complete
);
  a_r5_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[0] && status[1]));
  a_r8_gap_before_req: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status[0]) || $rose(status[1])) |-> $past(req_n));
  a_r7_expiry_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    expire[0] |=> (status[2] && !status[0]));
  a_r7_expiry_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    expire[1] |=> (status[3] && !status[1]));
  a_r6_complete_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    complete[0] |=> (!status[2] && !status[0]));
  a_r9_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    (grant[0] && dual_mode) |=> status[4]);
  a_r10_no_ch1_single: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_mode |-> !grant[1]);
endmodule

bind txreq_status_ctrl txreq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_n(req_n), .status(status),
  .dual_mode(dual_mode), .grant(grant), .expire(expire), .complete(complete)
);

// File: tb/tb_txreq_status_ctrl.sv
`timescale 1ns/1ps
module tb_txreq_status_ctrl;
  localparam int WIN_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       full_pulse = '0;
  logic [1:0]       done_pulse = '0;
  logic             dual_mode = 1'b0;
  logic             codec_pcm = 1'b0;
  logic             buf_20ms = 1'b0;
  logic [WIN_W-1:0] rd_window = 8'd4;
  logic             req_n;
  logic [7:0]       status;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  txreq_status_ctrl #(.WIN_W(WIN_W)) dut (
    .clk(clk), .rst_n(rst_n), .full_pulse(full_pulse), .done_pulse(done_pulse),
    .dual_mode(dual_mode), .codec_pcm(codec_pcm), .buf_20ms(buf_20ms),
    .rd_window(rd_window), .req_n(req_n), .status(status)
  );

  // Behavioural reference: a wait list of channels plus one live request.
  int m_live;          // -1 none, else channel number
  int m_left;          // clocks left in the window
  bit m_wait[2];
  bit m_err[2];
  bit m_first, m_codec, m_period, m_dual;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_live = -1; m_left = 0; m_wait[0] = 0; m_wait[1] = 0;
      m_err[0] = 0; m_err[1] = 0; m_first = 0;
      m_codec = 0; m_period = 0; m_dual = 0;
    end else begin
      int pick;
      pick = -1;
      if (m_live < 0) begin
        if (m_wait[0]) pick = 0;
        else if (m_wait[1]) pick = 1;
      end else if (done_pulse[m_live]) begin
        m_err[m_live] = 0; m_live = -1;
      end else if (m_left == 1) begin
        m_err[m_live] = 1; m_live = -1;
      end else begin
        m_left = m_left - 1;
      end
      if (pick >= 0) begin
        m_live = pick;
        m_left = (rd_window == 0) ? 1 : int'(rd_window);
        m_wait[pick] = 0;
      end
      if (full_pulse[0]) m_wait[0] = 1;
      if (full_pulse[1]) m_wait[1] = 1;
      if (!dual_mode) m_wait[1] = 0;
      if (!dual_mode) m_first = 0;
      else if (pick == 0) m_first = 1;
      else if (pick == 1) m_first = 0;
      m_codec = codec_pcm; m_period = buf_20ms; m_dual = dual_mode;
    end
  end

  task automatic check_bit(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", req, cycles, act, exp);
    end
  endtask

  // Per-field compare on every clock, away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check_bit("R2 codec flag",   status[7], m_codec);
      check_bit("R3 period flag",  status[6], m_period);
      check_bit("R4 dual flag",    status[5], m_dual);
      check_bit("R9 frame start",  status[4], m_first);
      check_bit("R7 err ch1",      status[3], m_err[1]);
      check_bit("R6 err ch0",      status[2], m_err[0]);
      check_bit("R5 req ch1",      status[1], m_live == 1);
      check_bit("R5 req ch0",      status[0], m_live == 0);
      check_bit("R8 req line",     req_n,     m_live < 0);
    end
  end

  task automatic drive(input logic [1:0] f, input logic [1:0] d);
    @(negedge clk); #1;
    full_pulse = f; done_pulse = d;
    @(negedge clk); #1;
    full_pulse = '0; done_pulse = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    idle(2);
    check_bit("R1 reset status", status == 8'h00, 1'b1);
    check_bit("R1 reset req_n", req_n, 1'b1);
    #1 rst_n = 1'b1;
    idle(2);
    check_bit("R1 after release", status == 8'h00, 1'b1);

    // R2, R3: mode flags
    codec_pcm = 1'b1; buf_20ms = 1'b1;
    idle(3);
    codec_pcm = 1'b0;
    idle(2);

    // R5, R6: single mode ch0 read on time
    drive(2'b01, 2'b00);
    idle(1);
    check_bit("R5 ch0 request up", status[0], 1'b1);
    drive(2'b00, 2'b01);
    check_bit("R6 ch0 cleared", status[0], 1'b0);

    // R7: ch0 expiry, window 4
    drive(2'b01, 2'b00);
    idle(6);
    check_bit("R7 ch0 error set", status[2], 1'b1);

    // R11: stray done leaves the error alone
    drive(2'b00, 2'b01);
    check_bit("R11 error kept", status[2], 1'b1);

    // R10: ch1 pulse in single mode ignored
    drive(2'b10, 2'b00);
    idle(4);
    check_bit("R10 no ch1 request", status[1] | ~req_n, 1'b0);

    // R4, R9: dual mode, both channels full in the same cycle
    dual_mode = 1'b1;
    idle(2);
    drive(2'b11, 2'b00);
    idle(1);
    check_bit("R9 frame start on ch0", status[4], 1'b1);
    drive(2'b00, 2'b01);
    idle(2);
    check_bit("R9 frame start cleared on ch1", status[4], 1'b0);
    check_bit("R5 ch1 follows ch0", status[1], 1'b1);
    idle(6);
    check_bit("R7 ch1 error set", status[3], 1'b1);

    // R7: window 0 acts as 1, window 1
    rd_window = 8'd0;
    drive(2'b01, 2'b00);
    idle(3);
    rd_window = 8'd1;
    drive(2'b10, 2'b00);
    idle(3);

    // R6: done on the last window cycle wins over expiry
    rd_window = 8'd3;
    drive(2'b10, 2'b00);
    idle(2);
    drive(2'b00, 2'b10);
    idle(1);
    check_bit("R6 ch1 error cleared", status[3], 1'b0);

    // R8: back-to-back frames, stray done on idle ch1
    for (int k = 0; k < 4; k++) begin
      drive(2'b11, 2'b10);
      idle(3 + k);
      drive(2'b00, 2'b01);
      idle(5);
    end

    // R10: mode leaves with ch1 pending
    rd_window = 8'd6;
    drive(2'b11, 2'b00);
    dual_mode = 1'b0;
    idle(16);
    check_bit("R10 pending ch1 dropped", status[1], 1'b0);
    idle(2);
    finish_run();
  end
endmodule